// File: doc/BRIEF.md
# Static Memory Bank Sequencer

This block turns one read or write request from an on-chip bus into one or more cycles on an external static memory bus. It drives an active-low chip select, an active-low write strobe, a 24-bit address and write data, and it accepts read data plus an active-low wait line from the device. The request carries a bank number. The block uses that number to pick the bank's settings from configuration inputs: a wait-state count, an external data width and a write-protect flag.

If the bank is narrower than the transfer, the block splits the transfer into consecutive external cycles. It steps the address on each one, sends the write data out one slice at a time, and collects read slices into a buffer. The requester sees ready held low until the whole request has finished. A request that is refused gets a two-cycle error response and causes no external cycle. A request is refused when it writes to a protected bank or when its address does not suit its size.

Top module: `smc_bank_seq`

## Requirements
- R1: After reset, `mem_cs_no` and `mem_we_no` are high, `ready_o` is high and `err_o` is low.
- R2: A request is taken on a rising edge where `req_i` is high while `ready_o` is high and `err_o` is low. From the next cycle, `ready_o` stays low until a single completion cycle with `ready_o` high and `err_o` low. No external activity occurs in that completion cycle.
- R3: Each external cycle's wait phase lasts max(N, L) clocks. N is the bank's wait count (valid range 2..31). L is the number of clocks until `mem_wait_ni` is sampled high on a rising edge.
- R4: Chip select and the address become valid together in the first cycle after acceptance. A read never lowers `mem_we_no`. The read data is captured on the edge that ends the wait phase, and chip select stays low for one more hold cycle.
- R5: A write strobe goes low in the second wait-phase cycle and stays low through the end of the wait phase, so it lasts N-1 clocks when the wait line is idle. It goes high in the hold cycle. Address and write data stay stable while it is low.
- R6: If `next_write_i` is high on the edge that ends the last wait phase of a request, the hold cycle is skipped and chip select rises one cycle early.
- R7: Width code 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. A transfer wider than the bank is issued as 2^(size-width) external cycles, each with its own wait phase and hold cycle. The address advances by 1 per cycle on 8-bit banks and by 2 on 16-bit banks.
- R8: Read slices come from the low lanes of `mem_rdata_i` and are packed least significant first into `rdata_o`. `rdata_o` is valid in the completion cycle. Bits above the transfer size are zero.
- R9: Write data is sent least significant slice first. External cycle k drives `req_wdata_i` shifted right by k times the bank width on the low lanes of `mem_wdata_o`.
- R10: A write to a bank with its protect bit set causes no external cycle. The response is one cycle with `ready_o` low and `err_o` high, then one cycle with both high, then `err_o` low.
- R11: A halfword request (size 1) at an odd address, or a word request (size 2) whose address bits [1:0] are not 00, gets the same error response as R10, for reads as well as writes.
- R12: The wait count, width and protect bit come from the bank chosen by `req_bank_i` on the acceptance edge. Each bank occupies its own slice of the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| req_addr_i | input | 24 | Byte address of the transfer |
| req_wdata_i | input | 32 | Write data, right-justified |
| req_bank_i | input | 2 | Bank number of the request |
| next_write_i | input | 1 | The following bus cycle is a write |
| cfg_wait_i | input | 20 | Per-bank wait count, 5 bits per bank |
| cfg_width_i | input | 8 | Per-bank width code, 2 bits per bank |
| cfg_wp_i | input | 4 | Per-bank write protect |
| ready_o | output | 1 | Ready / completion |
| err_o | output | 1 | Error response |
| rdata_o | output | 32 | Assembled read data |
| mem_cs_no | output | 1 | External chip select, active low |
| mem_we_no | output | 1 | External write strobe, active low |
| mem_addr_o | output | 24 | External address |
| mem_wdata_o | output | 32 | External write data |
| mem_rdata_i | input | 32 | External read data |
| mem_wait_ni | input | 1 | External wait, active low |

## Verification
The assertions assume that every bank's wait count is between 2 and 31 and that the configuration does not change while a request is in progress. They also assume that the external wait line only stretches a wait phase that has already started. The bench sets up the configuration once before the first request and keeps all wait counts at 2 to 5. It lowers the wait line only from the acceptance edge and releases it after a fixed number of clocks. It also holds `next_write_i` constant for the whole of each request, so the early-release decision always sees a settled value.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int unsigned WAIT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_HOLD,
    ST_DONE,
    ST_ERR1,
    ST_ERR2
  } smc_state_e;

  typedef struct packed {
    logic [WAIT_W-1:0] wait_n;
    logic [1:0]        width;
    logic              wp;
  } bank_cfg_t;
endpackage

// File: rtl/smc_cfg_sel.sv
module smc_cfg_sel
  import smc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait_i,
  input  logic [NUM_BANKS*2-1:0]      cfg_width_i,
  input  logic [NUM_BANKS-1:0]        cfg_wp_i,
  input  logic [BANK_W-1:0]           bank_i,
  output bank_cfg_t                   cfg_o
);
  bank_cfg_t tbl [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign tbl[b] = '{wait_n: cfg_wait_i[b*WAIT_W +: WAIT_W],
                      width:  cfg_width_i[b*2 +: 2],
                      wp:     cfg_wp_i[b]};
  end

  assign cfg_o = tbl[bank_i];
endmodule

// File: rtl/smc_beat_plan.sv
module smc_beat_plan (
  input  logic [1:0] size_i,
  input  logic [1:0] width_i,
  input  logic [1:0] addr_lo_i,
  input  logic       write_i,
  input  logic       wp_i,
  output logic [1:0] beats_m1_o,
  output logic       err_o
);
  logic misalign;

  always_comb begin
    misalign = ((size_i == 2'd1) && addr_lo_i[0]) ||
               ((size_i >= 2'd2) && (addr_lo_i != 2'b00));
    err_o = misalign || (write_i && wp_i);
    beats_m1_o = 2'd0;
    if (size_i > width_i) begin
      beats_m1_o = ((size_i - width_i) == 2'd1) ? 2'd1 : 2'd3;
    end
  end
endmodule

// File: rtl/smc_data_pack.sv
module smc_data_pack #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [1:0]        beat_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [DATA_W-1:0] rbuf_q;
  logic [DATA_W-1:0] rd_lane;
  int unsigned       shamt;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] code);
    int unsigned bits;
    bits = 32'd8 << code;
    if (bits > DATA_W) bits = DATA_W;
    return {DATA_W{1'b1}} >> (DATA_W - bits);
  endfunction

  always_comb begin
    shamt       = 32'(beat_i) << (32'(width_i) + 32'd3);
    rd_lane     = mem_rdata_i & lane_mask(width_i);
    mem_wdata_o = wdata_i >> shamt;
    rdata_o     = rbuf_q & lane_mask(size_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
    end else if (capture_i) begin
      rbuf_q <= ((beat_i == 2'd0) ? '0 : rbuf_q) | (rd_lane << shamt);
    end
  end
endmodule

// File: rtl/smc_bank_seq.sv
module smc_bank_seq
  import smc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        req_write_i,
  input  logic [1:0]                  req_size_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  input  logic [BANK_W-1:0]           req_bank_i,
  input  logic                        next_write_i,
  input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait_i,
  input  logic [NUM_BANKS*2-1:0]      cfg_width_i,
  input  logic [NUM_BANKS-1:0]        cfg_wp_i,
  output logic                        ready_o,
  output logic                        err_o,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        mem_cs_no,
  output logic                        mem_we_no,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  input  logic                        mem_wait_ni
);
  smc_state_e        st_q, st_d;
  bank_cfg_t         sel_cfg, cfg_q;
  logic [1:0]        plan_beats_m1, beats_m1_q, beat_q, size_q;
  logic              plan_err, write_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W:0]   cnt_inc;
  logic              accept, acc_done, last_beat, capture;

  smc_cfg_sel #(.NUM_BANKS(NUM_BANKS)) u_cfg_sel (
    .cfg_wait_i (cfg_wait_i),
    .cfg_width_i(cfg_width_i),
    .cfg_wp_i   (cfg_wp_i),
    .bank_i     (req_bank_i),
    .cfg_o      (sel_cfg)
  );

  smc_beat_plan u_plan (
    .size_i    (req_size_i),
    .width_i   (sel_cfg.width),
    .addr_lo_i (req_addr_i[1:0]),
    .write_i   (req_write_i),
    .wp_i      (sel_cfg.wp),
    .beats_m1_o(plan_beats_m1),
    .err_o     (plan_err)
  );

  smc_data_pack #(.DATA_W(DATA_W)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .beat_i     (beat_q),
    .width_i    (cfg_q.width),
    .size_i     (size_q),
    .mem_rdata_i(mem_rdata_i),
    .wdata_i    (wdata_q),
    .rdata_o    (rdata_o),
    .mem_wdata_o(mem_wdata_o)
  );

  always_comb begin
    accept    = req_i && ((st_q == ST_IDLE) || (st_q == ST_DONE));
    cnt_inc   = {1'b0, cnt_q} + 1'b1;
    // wait phase ends on the later of count reached and wait released
    acc_done  = (st_q == ST_ACCESS) && (cnt_inc >= {1'b0, cfg_q.wait_n}) && mem_wait_ni;
    last_beat = (beat_q == beats_m1_q);
    capture   = acc_done && !write_q;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept) st_d = plan_err ? ST_ERR1 : ST_ACCESS;
        else        st_d = ST_IDLE;
      end
      ST_ACCESS: begin
        if (acc_done) st_d = (last_beat && next_write_i) ? ST_DONE : ST_HOLD;
      end
      ST_HOLD:  st_d = last_beat ? ST_DONE : ST_ACCESS;
      ST_ERR1:  st_d = ST_ERR2;
      ST_ERR2:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cfg_q      <= '0;
      beats_m1_q <= '0;
      beat_q     <= '0;
      size_q     <= '0;
      write_q    <= 1'b0;
      base_q     <= '0;
      wdata_q    <= '0;
      cnt_q      <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        cfg_q      <= sel_cfg;
        beats_m1_q <= plan_beats_m1;
        beat_q     <= '0;
        size_q     <= req_size_i;
        write_q    <= req_write_i;
        base_q     <= req_addr_i;
        wdata_q    <= req_wdata_i;
        cnt_q      <= '0;
      end else if (st_q == ST_ACCESS && !acc_done && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (st_q == ST_HOLD && !last_beat) begin
        beat_q <= beat_q + 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  always_comb begin
    ready_o    = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR2);
    err_o      = (st_q == ST_ERR1) || (st_q == ST_ERR2);
    mem_cs_no  = !((st_q == ST_ACCESS) || (st_q == ST_HOLD));
    mem_we_no  = !((st_q == ST_ACCESS) && write_q && (cnt_q != '0));
    mem_addr_o = base_q + (ADDR_W'(beat_q) << cfg_q.width);
  end
endmodule

// File: rtl/smc_bank_seq_chk.sv
module smc_bank_seq_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              err_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_wait_ni
);
  assert_we_in_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_cs_no);

  assert_wdata_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> ($stable(mem_wdata_o) && $stable(mem_addr_o)));

  assert_wait_stretch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && !mem_wait_ni) |=> !mem_we_no);

  assert_busy_not_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_no |-> !ready_o);

  assert_err_no_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> mem_cs_no);

  assert_err_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !ready_o);

  assert_err_second_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |=> (ready_o && err_o));

  assert_err_ends_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && ready_o) |=> !err_o);
endmodule

bind smc_bank_seq smc_bank_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .err_o      (err_o),
  .mem_cs_no  (mem_cs_no),
  .mem_we_no  (mem_we_no),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_wait_ni(mem_wait_ni)
);

// File: tb/smc_bank_seq_test.sv
`timescale 1ns/1ps
module smc_bank_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0, next_write_i = 1'b0;
  logic [1:0]  req_size_i = '0, req_bank_i = '0;
  logic [23:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [19:0] cfg_wait_i;
  logic [7:0]  cfg_width_i;
  logic [3:0]  cfg_wp_i;
  logic        ready_o, err_o, mem_cs_no, mem_we_no;
  logic [31:0] rdata_o, mem_wdata_o, mem_rdata_i;
  logic [23:0] mem_addr_o;
  logic        mem_wait_ni = 1'b1;

  int checks = 0, errors = 0;
  int obs_low, obs_beats, obs_we, obs_cs, obs_wbeats;
  logic obs_err;
  logic [31:0] obs_rdata;
  logic [23:0] obs_addr [8];
  logic [31:0] obs_wd [8];

  always #10 clk_i = ~clk_i;

  // bank0: 32b N3; bank1: 8b N2; bank2: 16b N4; bank3: 32b N5 protected
  assign cfg_wait_i  = {5'd5, 5'd4, 5'd2, 5'd3};
  assign cfg_width_i = {2'd2, 2'd1, 2'd0, 2'd2};
  assign cfg_wp_i    = 4'b1000;

  function automatic logic [7:0] bytev(input logic [23:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  function automatic logic [31:0] memw(input logic [23:0] a);
    return {bytev(a + 24'd3), bytev(a + 24'd2), bytev(a + 24'd1), bytev(a)};
  endfunction

  assign mem_rdata_i = memw(mem_addr_o);

  smc_bank_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
    .req_size_i(req_size_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_bank_i(req_bank_i), .next_write_i(next_write_i), .cfg_wait_i(cfg_wait_i),
    .cfg_width_i(cfg_width_i), .cfg_wp_i(cfg_wp_i), .ready_o(ready_o), .err_o(err_o),
    .rdata_o(rdata_o), .mem_cs_no(mem_cs_no), .mem_we_no(mem_we_no),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_wait_ni(mem_wait_ni)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic wr, input logic [1:0] sz, input logic [23:0] a,
                          input logic [31:0] wd, input logic [1:0] bk, input logic nw,
                          input int wait_len);
    logic prev_cs, prev_we;
    logic [23:0] prev_addr;
    @(negedge clk_i);
    req_i = 1'b1; req_write_i = wr; req_size_i = sz; req_addr_i = a;
    req_wdata_i = wd; req_bank_i = bk; next_write_i = nw;
    mem_wait_ni = (wait_len == 0);
    obs_low = 0; obs_beats = 0; obs_we = 0; obs_cs = 0; obs_wbeats = 0;
    obs_err = 1'b0; obs_rdata = '0;
    prev_cs = 1'b1; prev_we = 1'b1; prev_addr = '0;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int m = 1; m < 300; m++) begin
      if (m > 1) @(negedge clk_i);
      if (ready_o) begin
        obs_err = err_o; obs_rdata = rdata_o;
        break;
      end
      obs_low++;
      if (!mem_cs_no) begin
        obs_cs++;
        if ((prev_cs || mem_addr_o != prev_addr) && obs_beats < 8) begin
          obs_addr[obs_beats] = mem_addr_o;
          obs_beats++;
        end
      end
      if (!mem_we_no) begin
        obs_we++;
        if (prev_we && obs_wbeats < 8) begin
          obs_wd[obs_wbeats] = mem_wdata_o;
          obs_wbeats++;
        end
      end
      prev_cs = mem_cs_no; prev_we = mem_we_no; prev_addr = mem_addr_o;
      if (wait_len > 0 && m == wait_len) mem_wait_ni = 1'b1;
    end
    mem_wait_ni = 1'b1; next_write_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(mem_cs_no && mem_we_no, "R1 strobes idle", {30'd0, mem_cs_no, mem_we_no}, 32'd3);
    chk(ready_o && !err_o, "R1 response idle", {30'd0, ready_o, err_o}, 32'd2);
  endtask

  task automatic t_read_word32();
    run_xfer(1'b0, 2'd2, 24'h000100, '0, 2'd0, 1'b0, 0);
    chk(obs_low == 4, "R2 R3 busy cycles N=3", obs_low, 4);
    chk(obs_cs == 4 && obs_beats == 1, "R4 cs with hold", obs_cs, 4);
    chk(obs_addr[0] == 24'h000100, "R4 address", {8'd0, obs_addr[0]}, 32'h100);
    chk(obs_we == 0, "R4 no write strobe on read", obs_we, 0);
    chk(!obs_err && obs_rdata == memw(24'h100), "R8 word data", obs_rdata, memw(24'h100));
  endtask

  task automatic t_read_split8();
    run_xfer(1'b0, 2'd2, 24'h001234, '0, 2'd1, 1'b0, 0);
    chk(obs_low == 12, "R7 R12 four byte cycles", obs_low, 12);
    chk(obs_beats == 4, "R7 beat count", obs_beats, 4);
    for (int i = 0; i < 4; i++)
      chk(obs_addr[i] == 24'h001234 + 24'(i), "R7 byte address step",
          {8'd0, obs_addr[i]}, {8'd0, 24'h001234 + 24'(i)});
    chk(obs_rdata == memw(24'h001234), "R8 packed bytes", obs_rdata, memw(24'h001234));
  endtask

  task automatic t_read_split16();
    run_xfer(1'b0, 2'd2, 24'h00ABC8, '0, 2'd2, 1'b0, 0);
    chk(obs_low == 10, "R7 R12 two halfword cycles N=4", obs_low, 10);
    chk(obs_beats == 2 && obs_addr[1] == 24'h00ABCA, "R7 halfword address step",
        {8'd0, obs_addr[1]}, 32'h00ABCA);
    chk(obs_rdata == memw(24'h00ABC8), "R8 packed halfwords", obs_rdata, memw(24'h00ABC8));
  endtask

  task automatic t_read_byte();
    run_xfer(1'b0, 2'd0, 24'h000103, '0, 2'd0, 1'b0, 0);
    chk(obs_rdata == {24'd0, bytev(24'h103)}, "R8 zero above size",
        obs_rdata, {24'd0, bytev(24'h103)});
  endtask

  task automatic t_wait_stretch();
    run_xfer(1'b0, 2'd2, 24'h000200, '0, 2'd0, 1'b0, 7);
    chk(obs_low == 8, "R3 wait longer than N", obs_low, 8);
    run_xfer(1'b0, 2'd2, 24'h000204, '0, 2'd3, 1'b0, 2);
    chk(obs_low == 6, "R3 N longer than wait", obs_low, 6);
    chk(!obs_err, "R10 read of protected bank allowed", obs_err, 0);
  endtask

  task automatic t_write_split();
    run_xfer(1'b1, 2'd2, 24'h000040, 32'hDEADBEEF, 2'd1, 1'b0, 0);
    chk(obs_low == 12 && !obs_err, "R7 write split busy", obs_low, 12);
    chk(obs_we == 4 && obs_wbeats == 4, "R5 strobe N-1 per cycle", obs_we, 4);
    for (int i = 0; i < 4; i++)
      chk(obs_wd[i][7:0] == 8'(32'hDEADBEEF >> (8*i)), "R9 byte slice order",
          {24'd0, obs_wd[i][7:0]}, {24'd0, 8'(32'hDEADBEEF >> (8*i))});
    chk(obs_addr[3] == 24'h000043, "R7 write address step", {8'd0, obs_addr[3]}, 32'h43);
  endtask

  task automatic t_write_half();
    run_xfer(1'b1, 2'd1, 24'h000202, 32'h0000CAFE, 2'd2, 1'b0, 0);
    chk(obs_low == 5 && obs_we == 3, "R5 strobe length N=4", obs_we, 3);
    chk(obs_wd[0][15:0] == 16'hCAFE, "R9 halfword data", {16'd0, obs_wd[0][15:0]}, 32'hCAFE);
  endtask

  task automatic t_early_drop();
    run_xfer(1'b0, 2'd2, 24'h000300, '0, 2'd0, 1'b1, 0);
    chk(obs_low == 3 && obs_cs == 3, "R6 hold skipped on read", obs_cs, 3);
    chk(obs_rdata == memw(24'h300), "R6 data still captured", obs_rdata, memw(24'h300));
    run_xfer(1'b1, 2'd2, 24'h000044, 32'h01020304, 2'd1, 1'b1, 0);
    chk(obs_low == 11, "R6 only last hold skipped", obs_low, 11);
  endtask

  task automatic t_protect();
    run_xfer(1'b1, 2'd2, 24'h000400, 32'h12345678, 2'd3, 1'b0, 0);
    chk(obs_low == 1 && obs_err, "R10 two-cycle error", obs_low, 1);
    chk(obs_cs == 0, "R10 no external cycle", obs_cs, 0);
    @(negedge clk_i);
    chk(!err_o && ready_o, "R10 error released", {30'd0, ready_o, err_o}, 32'd2);
  endtask

  task automatic t_misalign();
    run_xfer(1'b0, 2'd1, 24'h000101, '0, 2'd0, 1'b0, 0);
    chk(obs_err && obs_cs == 0, "R11 odd halfword", obs_err, 1);
    run_xfer(1'b0, 2'd2, 24'h000102, '0, 2'd1, 1'b0, 0);
    chk(obs_err && obs_cs == 0 && obs_low == 1, "R11 word at 10b", obs_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_read_word32();
    t_read_split8();
    t_read_split16();
    t_read_byte();
    t_wait_stretch();
    t_write_split();
    t_write_half();
    t_early_drop();
    t_protect();
    t_misalign();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule